// File: doc/BRIEF.md
# Mirrored Byte-Count Table Writer

This block turns one descriptor's length into writes to a per-queue table of 16-bit byte-count entries kept in external memory. Every queue owns a table region with a fixed 1024-byte stride from a common base. Each region holds 256 main entries followed by 64 mirror entries, for 640 bytes of entries. The rest of the stride is padding. The 16 regions together take 16 KB.

A request carries a queue number, a sequence number and a 12-bit length. The entry index is the sequence number reduced to its low 8 bits. The block always writes the entry at that index. When the index lies in the first 64 slots, it also writes the same value at index + 256. Because of that copy, a consumer can read any 64-entry window of the table as one contiguous run and never has to wrap.

Writes leave through a single valid/ready memory command port, one 16-bit entry per command. While the block is sending the one or two writes of a request, it holds its request-ready output low.

Top module: `bct_writer`

## Requirements
- R1: After reset, `mem_valid` is 0, `busy` is 0, `req_ready` is 1 and the stored base field is 0.
- R2: The first write of a request goes to byte address `{base_field, 10'b0} + queue*1024 + idx*2`, where `idx = req_seq[7:0]`. The address is always even.
- R3: Every write carries the request length zero-extended to 16 bits, so `mem_data[15:12]` is always 0.
- R4: When `idx < 64`, the first write is followed by a second write. The second write is presented in the cycle after the first is accepted. It goes to the first write's address + 512 (entry idx + 256) and carries the same data.
- R5: When `idx >= 64`, the request makes exactly one write. After a final write is accepted, `mem_valid` and `busy` are 0 in the next cycle.
- R6: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` do not change.
- R7: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `busy` and `mem_valid` are 1 from the next cycle until the last write is accepted. `req_ready` is the inverse of `busy`, and requests presented while busy leave no trace in the memory.
- R8: A `cfg_we` pulse stores `cfg_base`, which holds byte-address bits 35:10, so the table base is always 1024-byte aligned. A base change made while a request is in flight does not alter that request's addresses, and it applies to later requests.
- R9: Boundary entries follow R2 to R5: index 63 is mirrored, index 64 is not, and queue 15 lands at base + 15360.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the table base field |
| cfg_base | input | 26 | Base byte-address bits 35:10 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_queue | input | 4 | Queue number |
| req_seq | input | 12 | Sequence number; low 8 bits index the table |
| req_len | input | 12 | Byte count to store |
| mem_valid | output | 1 | Write command present |
| mem_ready | input | 1 | Memory accepts the command |
| mem_addr | output | 36 | Byte address of the entry |
| mem_data | output | 16 | Entry value |
| busy | output | 1 | Request in progress |

## Verification
The bench uses the default parameters: 16 queues, 256 main entries, a 64-entry mirror, a 36-bit address and a 1024-byte stride. With these values, the index boundary between 63 and 64 is reachable, as are the top queue and full-width bases that carry into high address bits. Random stall patterns on `mem_ready` exercise holding a command across many cycles and in between the two writes of a mirrored request. A base change during a stalled request and a refused request during a stall show that in-flight addresses are frozen and that requests presented while busy are dropped.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MAIN   = 2'd1,
    ST_MIRROR = 2'd2
  } bct_state_e;

endpackage

// File: rtl/bct_base_reg.sv
// Holds the table base as upper address bits only; alignment is implicit.
module bct_base_reg #(
  parameter int BASE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [BASE_W-1:0] cfg_base,
  output logic [BASE_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base;
    end
  end

endmodule

// File: rtl/bct_addr_gen.sv
// Combinational address arithmetic for the main entry and its mirror copy.
module bct_addr_gen #(
  parameter int ADDR_W         = 36,
  parameter int ALIGN_SHIFT    = 10,
  parameter int Q_W            = 4,
  parameter int IDX_W          = 8,
  parameter int MAIN_ENTRIES   = 256,
  parameter int MIRROR_ENTRIES = 64,
  parameter int ENTRY_SHIFT    = 1,
  localparam int BASE_W        = ADDR_W - ALIGN_SHIFT
) (
  input  logic [BASE_W-1:0] base_field,
  input  logic [Q_W-1:0]    queue,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] prim_addr,
  output logic [ADDR_W-1:0] mirr_addr,
  output logic              need_mirror
);

  logic [ADDR_W-1:0] table_base;
  logic [ADDR_W-1:0] queue_off;
  logic [ADDR_W-1:0] main_off;
  logic [ADDR_W-1:0] mirr_off;
  logic [IDX_W:0]    mirr_idx;

  always_comb begin
    table_base  = {base_field, {ALIGN_SHIFT{1'b0}}};
    queue_off   = ADDR_W'(queue) << ALIGN_SHIFT;
    main_off    = ADDR_W'(idx) << ENTRY_SHIFT;
    mirr_idx    = {1'b0, idx} + (IDX_W+1)'(MAIN_ENTRIES);
    mirr_off    = ADDR_W'(mirr_idx) << ENTRY_SHIFT;
    prim_addr   = table_base + queue_off + main_off;
    mirr_addr   = table_base + queue_off + mirr_off;
    need_mirror = ({{(32-IDX_W){1'b0}}, idx} < 32'(MIRROR_ENTRIES));
  end

endmodule

// File: rtl/bct_issue_fsm.sv
// Sequences one or two write commands with registered outputs.
module bct_issue_fsm
  import bct_pkg::*;
#(
  parameter int ADDR_W  = 36,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  prim_addr,
  input  logic [ADDR_W-1:0]  mirr_addr,
  input  logic               need_mirror,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               mem_ready,
  output logic               mem_valid,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_data,
  output logic               busy
);

  bct_state_e        state;
  logic [ADDR_W-1:0] mirr_q;
  logic              mirr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
      mirr_q    <= '0;
      mirr_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_MAIN;
            mem_valid <= 1'b1;
            mem_addr  <= prim_addr;
            mem_data  <= entry;
            mirr_q    <= mirr_addr;
            mirr_pend <= need_mirror;
          end
        end
        ST_MAIN: begin
          if (mem_ready) begin
            if (mirr_pend) begin
              state    <= ST_MIRROR;
              mem_addr <= mirr_q;
            end else begin
              state     <= ST_IDLE;
              mem_valid <= 1'b0;
            end
          end
        end
        ST_MIRROR: begin
          if (mem_ready) begin
            state     <= ST_IDLE;
            mem_valid <= 1'b0;
            mirr_pend <= 1'b0;
          end
        end
        default: begin
          state     <= ST_IDLE;
          mem_valid <= 1'b0;
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/bct_writer.sv
// Top: byte-count table writer with mirrored low-window entries.
module bct_writer #(
  parameter int NUM_QUEUES     = 16,
  parameter int MAIN_ENTRIES   = 256,
  parameter int MIRROR_ENTRIES = 64,
  parameter int ADDR_W         = 36,
  parameter int ALIGN_SHIFT    = 10,
  parameter int SEQ_W          = 12,
  parameter int LEN_W          = 12,
  parameter int ENTRY_W        = 16,
  localparam int Q_W           = $clog2(NUM_QUEUES),
  localparam int IDX_W         = $clog2(MAIN_ENTRIES),
  localparam int BASE_W        = ADDR_W - ALIGN_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [BASE_W-1:0]  cfg_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [Q_W-1:0]     req_queue,
  input  logic [SEQ_W-1:0]   req_seq,
  input  logic [LEN_W-1:0]   req_len,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_data,
  output logic               busy
);

  logic [BASE_W-1:0]  base_q;
  logic [ADDR_W-1:0]  prim_addr;
  logic [ADDR_W-1:0]  mirr_addr;
  logic               need_mirror;
  logic [IDX_W-1:0]   idx;
  logic [ENTRY_W-1:0] entry;
  logic               start;

  generate
    if (SEQ_W > IDX_W) begin : g_seq_wide
      logic unused_seq_hi;
      assign unused_seq_hi = ^req_seq[SEQ_W-1:IDX_W];
    end
  endgenerate

  assign idx       = req_seq[IDX_W-1:0];
  assign entry     = ENTRY_W'(req_len);
  assign req_ready = ~busy;
  assign start     = req_valid & req_ready;

  bct_base_reg #(.BASE_W(BASE_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_base (cfg_base),
    .base_q   (base_q)
  );

  bct_addr_gen #(
    .ADDR_W         (ADDR_W),
    .ALIGN_SHIFT    (ALIGN_SHIFT),
    .Q_W            (Q_W),
    .IDX_W          (IDX_W),
    .MAIN_ENTRIES   (MAIN_ENTRIES),
    .MIRROR_ENTRIES (MIRROR_ENTRIES),
    .ENTRY_SHIFT    (1)
  ) u_addr (
    .base_field  (base_q),
    .queue       (req_queue),
    .idx         (idx),
    .prim_addr   (prim_addr),
    .mirr_addr   (mirr_addr),
    .need_mirror (need_mirror)
  );

  bct_issue_fsm #(
    .ADDR_W  (ADDR_W),
    .ENTRY_W (ENTRY_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .prim_addr   (prim_addr),
    .mirr_addr   (mirr_addr),
    .need_mirror (need_mirror),
    .entry       (entry),
    .mem_ready   (mem_ready),
    .mem_valid   (mem_valid),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .busy        (busy)
  );

endmodule

// File: rtl/bct_writer_chk.sv
module bct_writer_chk #(
  parameter int ADDR_W         = 36,
  parameter int ALIGN_SHIFT    = 10,
  parameter int MAIN_ENTRIES   = 256,
  parameter int MIRROR_ENTRIES = 64,
  parameter int LEN_W          = 12,
  parameter int ENTRY_W        = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               busy,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [ENTRY_W-1:0] mem_data
);

  localparam logic [ALIGN_SHIFT-1:0] MIR_LIMIT = ALIGN_SHIFT'(MIRROR_ENTRIES * 2);
  localparam logic [ADDR_W-1:0]      MIR_STEP  = ADDR_W'(MAIN_ENTRIES * 2);

  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[0] == 1'b0)); // R2

  AST_DATA_ZEXT: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_data[ENTRY_W-1:LEN_W] == '0)); // R3

  AST_MIRROR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && (mem_addr[ALIGN_SHIFT-1:0] < MIR_LIMIT)) |=>
    (mem_valid && (mem_addr == $past(mem_addr) + MIR_STEP) && (mem_data == $past(mem_data)))); // R4

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && (mem_addr[ALIGN_SHIFT-1:0] >= MIR_LIMIT)) |=>
    (!mem_valid && !busy)); // R5

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
    (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R6

  AST_TAKE_START: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_valid && busy)); // R7

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready); // R7

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy); // R7

endmodule

bind bct_writer bct_writer_chk #(
  .ADDR_W         (ADDR_W),
  .ALIGN_SHIFT    (ALIGN_SHIFT),
  .MAIN_ENTRIES   (MAIN_ENTRIES),
  .MIRROR_ENTRIES (MIRROR_ENTRIES),
  .LEN_W          (LEN_W),
  .ENTRY_W        (ENTRY_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data)
);

// File: tb/tb_bct_writer.sv
module tb_bct_writer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [25:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_queue = '0;
  logic [11:0] req_seq = '0;
  logic [11:0] req_len = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [35:0] mem_addr;
  logic [15:0] mem_data;
  logic        busy;

  always #10 clk = ~clk;

  bct_writer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
    .req_seq(req_seq), .req_len(req_len), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ready_mode = 2;      // 0 random, 1 stall, 2 always ready
  logic [25:0] cur_base = '0;
  logic [35:0] log_addr[$];
  logic [15:0] log_data[$];

  always @(negedge clk) begin
    case (ready_mode)
      0: mem_ready = ($urandom % 3) != 0;
      1: mem_ready = 1'b0;
      default: mem_ready = 1'b1;
    endcase
  end

  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready) begin
      log_addr.push_back(mem_addr);
      log_data.push_back(mem_data);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_addr(input logic [25:0] b, input int q, input int ent);
    return {b, 10'b0} + 36'(q) * 36'd1024 + 36'(ent) * 36'd2;
  endfunction

  task automatic set_base(input logic [25:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_base = b;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_base = b;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic verify(input logic [25:0] b, input int q, input logic [11:0] seq, input logic [11:0] len);
    int idx;
    int n;
    idx = int'(seq[7:0]);
    n = (idx < 64) ? 2 : 1;
    check(log_addr.size() == n, (n == 2) ? "R4 write count" : "R5 write count", 64'(log_addr.size()), 64'(n));
    if (log_addr.size() >= 1) begin
      check(log_addr[0] == exp_addr(b, q, idx), "R2 main address", 64'(log_addr[0]), 64'(exp_addr(b, q, idx)));
      check(log_data[0] == {4'b0, len}, "R3 main data", 64'(log_data[0]), 64'(len));
    end
    if (n == 2 && log_addr.size() >= 2) begin
      check(log_addr[1] == exp_addr(b, q, idx + 256), "R4 mirror address", 64'(log_addr[1]), 64'(exp_addr(b, q, idx + 256)));
      check(log_data[1] == {4'b0, len}, "R4 mirror data", 64'(log_data[1]), 64'(len));
    end
    log_addr.delete();
    log_data.delete();
  endtask

  // Issues one request from idle, returns busy length in cycles.
  task automatic send(input int q, input logic [11:0] seq, input logic [11:0] len, output int busy_cyc);
    int c;
    @(negedge clk);
    req_valid = 1'b1; req_queue = 4'(q); req_seq = seq; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && mem_valid, "R7 busy after accept", 64'({busy, mem_valid}), 64'h3);
    wait_idle(c);
    busy_cyc = c;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int bc;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_valid && !busy && req_ready, "R1 reset outputs", 64'({mem_valid, busy, req_ready}), 64'h1);

    // R1: base resets to 0; R5 single write, one busy cycle when always ready
    ready_mode = 2;
    send(2, 12'h046, 12'h123, bc);
    check(bc == 1, "R5 busy length", 64'(bc), 64'd1);
    verify(26'h0, 2, 12'h046, 12'h123);

    // R4 mirrored write: two busy cycles when always ready
    send(5, 12'h310, 12'hfff, bc);
    check(bc == 2, "R4 busy length", 64'(bc), 64'd2);
    verify(26'h0, 5, 12'h310, 12'hfff);

    // R9 boundaries, R8 new base
    set_base(26'h3ff_ffff);
    send(15, 12'h03f, 12'h001, bc); verify(cur_base, 15, 12'h03f, 12'h001);
    send(15, 12'h040, 12'h800, bc); verify(cur_base, 15, 12'h040, 12'h800);
    send(0, 12'h000, 12'h000, bc);  verify(cur_base, 0, 12'h000, 12'h000);
    send(0, 12'hfff, 12'h7a5, bc);  verify(cur_base, 0, 12'hfff, 12'h7a5);

    // R7 refused request while busy, R6 held under stall
    set_base(26'h012_3456);
    ready_mode = 1;
    @(negedge clk);
    req_valid = 1'b1; req_queue = 4'd3; req_seq = 12'h105; req_len = 12'h0ab;
    @(negedge clk);
    req_queue = 4'd7; req_seq = 12'h0c8; req_len = 12'h555;
    for (int i = 0; i < 3; i++) begin
      check(!req_ready, "R7 ready low while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(mem_valid && mem_addr == exp_addr(cur_base, 3, 5), "R6 held address", 64'(mem_addr), 64'(exp_addr(cur_base, 3, 5)));
    ready_mode = 0;
    wait_idle(bc);
    verify(cur_base, 3, 12'h105, 12'h0ab);

    // R8 base change during stalled request
    ready_mode = 1;
    @(negedge clk);
    req_valid = 1'b1; req_queue = 4'd9; req_seq = 12'h021; req_len = 12'h321;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_base = 26'h2aa_aaaa;
    @(negedge clk);
    cfg_we = 1'b0;
    ready_mode = 0;
    wait_idle(bc);
    verify(cur_base, 9, 12'h021, 12'h321);
    cur_base = 26'h2aa_aaaa;
    send(9, 12'h021, 12'h321, bc);
    verify(cur_base, 9, 12'h021, 12'h321);

    // Random traffic with random stalls and occasional base changes
    ready_mode = 0;
    for (int k = 0; k < 300; k++) begin
      int q;
      logic [11:0] s;
      logic [11:0] l;
      q = int'($urandom % 16);
      s = 12'($urandom);
      l = 12'($urandom);
      case ($urandom % 8)
        0: s[7:0] = 8'd63;
        1: s[7:0] = 8'd64;
        2: s[7:0] = 8'd0;
        3: s[7:0] = 8'd255;
        default: ;
      endcase
      if ($urandom % 16 == 0) set_base(26'($urandom));
      send(q, s, l, bc);
      verify(cur_base, q, s, l);
    end

    summary();
    $finish;
  end

endmodule